// File: doc/BRIEF.md
# Bit-serial PHY tuning writer

This block loads tuning values into the configuration space of up to four analog PHYs that share one 16-bit control word. The PHY side accepts one bit per strobe. A request names a PHY, a start address, a data word and a bit count. The writer sends the value least significant bit first and places each bit at the next address up. For every bit it sets the address, then the data bit with the strobe low, then pulses the strobe bit that belongs to the chosen PHY.

Requests use a valid/ready handshake. While a transfer runs, the block reports busy and accepts nothing else, so transfers to different PHYs never interleave on the shared word. A per-request flag clears the whole control word before the first bit, which the newer register layout needs. Each strobe phase (setup, high, low) is held for `HOLD_CYC` clock cycles so that the PHY meets its setup and hold times.

Top module: `ptune_writer`

## Requirements
- R1: After reset, `ctl_o` is 0, `busy_o` and `done_o` are low and `req_ready_o` is high.
- R2: Control word layout: the address is in bits 15:8, the serial data bit is in bit 7, and the strobe for PHY p is bit 2p. Only the strobe of the requested PHY is ever raised, and bits 1, 3 and 5 stay 0.
- R3: Bit i of a transfer carries data bit i (LSB first) and is written to the start address plus i, modulo 256.
- R4: For each bit the word changes in this order: address; then data bit together with strobe low; then strobe high; then strobe low. Address and data do not change while a strobe is high.
- R5: With `req_clr_i`=1 the whole word reads 0 in the cycle after acceptance. With `req_clr_i`=0 the word keeps its previous value until the new address is set.
- R6: The setup, strobe-high and strobe-low phases each last `HOLD_CYC` cycles. A transfer of n≥1 bits keeps `busy_o` high for n·(2+3·`HOLD_CYC`)+1 cycles, starting the cycle after acceptance.
- R7: `req_ready_o` equals not `busy_o`. A request is taken at a clock edge where valid and ready are both high. A request held while busy waits and is taken later, never dropped. Request inputs that change during a transfer have no effect on it, and the word does not change while idle.
- R8: `done_o` is a one-cycle pulse in the last busy cycle of each transfer.
- R9: A bit count of 0 raises no strobe and ends after 2 busy cycles. A count above `DATA_W` is clamped to `DATA_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_phy_i | input | PHY_W | Target PHY index |
| req_addr_i | input | 8 | Start address |
| req_data_i | input | DATA_W | Value to send, LSB first |
| req_len_i | input | LEN_W | Number of bits |
| req_clr_i | input | 1 | Clear the control word before the first bit |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| ctl_o | output | 16 | Shared control word to the PHYs |

## Verification
The hardest case to reach is a request that is already waiting while another transfer runs. The waiting request must be taken exactly one cycle after the done pulse, and the inputs that changed during the previous transfer must not corrupt it. The bench issues chains of requests without waiting for idle, and scrambles the request fields right after each acceptance. The address wrap past 0xFF, the clamp of an oversize count and the zero-length request are each driven directly. A PHY-side capture model records the data bit at every strobe rising edge and checks the bit and its address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned CTL_W    = 16;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned ADDR_LSB = 8;
  localparam int unsigned DATA_BIT = 7;
  localparam int unsigned MAX_PHY  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_SETUP, ST_HIGH, ST_LOW, ST_FIN
  } ptw_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_CLEAR, OP_ADDR, OP_DATA, OP_RISE, OP_FALL
  } ptw_op_e;
endpackage

// File: rtl/ptw_req_reg.sv
module ptw_req_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PHY_W  = 2,
  parameter int unsigned LEN_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic                       step_i,
  input  logic [PHY_W-1:0]           phy_i,
  input  logic [ptw_pkg::ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic [LEN_W-1:0]           len_i,
  output logic [PHY_W-1:0]           phy_o,
  output logic [ptw_pkg::ADDR_W-1:0] addr_o,
  output logic                       bit_o,
  output logic                       last_o,
  output logic                       empty_o
);
  localparam logic [LEN_W-1:0] LenMax = LEN_W'(DATA_W);

  logic [PHY_W-1:0]           phy_q;
  logic [ptw_pkg::ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]          sh_q;
  logic [LEN_W-1:0]           left_q;
  logic [LEN_W-1:0]           len_eff;

  assign len_eff = (len_i > LenMax) ? LenMax : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q  <= '0;
      addr_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      phy_q  <= phy_i;
      addr_q <= addr_i;
      sh_q   <= data_i;
      left_q <= len_eff;
    end else if (step_i) begin
      addr_q <= addr_q + ptw_pkg::ADDR_W'(1);
      sh_q   <= sh_q >> 1;
      left_q <= left_q - LEN_W'(1);
    end
  end

  assign phy_o   = phy_q;
  assign addr_o  = addr_q;
  assign bit_o   = sh_q[0];
  assign last_o  = (left_q == LEN_W'(1));
  assign empty_o = (left_q == '0);
endmodule

// File: rtl/ptw_phase_timer.sv
module ptw_phase_timer #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned HC = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int unsigned TW = (HC > 1) ? $clog2(HC) : 1;
  localparam logic [TW-1:0] Reload = TW'(HC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= Reload;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ptw_ctl_word.sv
module ptw_ctl_word #(
  parameter int unsigned NUM_PHY = 4,
  parameter int unsigned PHY_W   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  ptw_pkg::ptw_op_e           op_i,
  input  logic [PHY_W-1:0]           phy_i,
  input  logic [ptw_pkg::ADDR_W-1:0] addr_i,
  input  logic                       bit_i,
  output logic [ptw_pkg::CTL_W-1:0]  ctl_o
);
  import ptw_pkg::*;

  logic [CTL_W-1:0] stb_mask;
  logic [CTL_W-1:0] ctl_q, ctl_d;

  // strobe of PHY g sits at bit 2g; odd bits never selected
  for (genvar g = 0; g < MAX_PHY; g++) begin : g_stb
    if (g < NUM_PHY) begin : g_used
      assign stb_mask[2*g] = (phy_i == PHY_W'(g));
    end else begin : g_unused
      assign stb_mask[2*g] = 1'b0;
    end
    assign stb_mask[2*g+1] = 1'b0;
  end
  assign stb_mask[CTL_W-1:2*MAX_PHY] = '0;

  always_comb begin
    ctl_d = ctl_q;
    unique case (op_i)
      OP_CLEAR: ctl_d = '0;
      OP_ADDR:  ctl_d[ADDR_LSB +: ADDR_W] = addr_i;
      OP_DATA: begin
        ctl_d = ctl_q & ~stb_mask;
        ctl_d[DATA_BIT] = bit_i;
      end
      OP_RISE:  ctl_d = ctl_q | stb_mask;
      OP_FALL:  ctl_d = ctl_q & ~stb_mask;
      default:  ctl_d = ctl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/ptw_seq_fsm.sv
module ptw_seq_fsm (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_clr_i,
  input  logic             expired_i,
  input  logic             last_i,
  input  logic             empty_i,
  output logic             load_o,
  output logic             step_o,
  output logic             tmr_load_o,
  output ptw_pkg::ptw_op_e op_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             done_o
);
  import ptw_pkg::*;

  ptw_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    step_o     = 1'b0;
    tmr_load_o = 1'b0;
    op_o       = OP_NONE;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        load_o = 1'b1;
        op_o   = req_clr_i ? OP_CLEAR : OP_NONE;
        st_d   = ST_ADDR;
      end
      ST_ADDR: begin
        if (empty_i) st_d = ST_FIN;
        else begin
          op_o = OP_ADDR;
          st_d = ST_DATA;
        end
      end
      ST_DATA: begin
        op_o       = OP_DATA;
        tmr_load_o = 1'b1;
        st_d       = ST_SETUP;
      end
      ST_SETUP: if (expired_i) begin
        op_o       = OP_RISE;
        tmr_load_o = 1'b1;
        st_d       = ST_HIGH;
      end
      ST_HIGH: if (expired_i) begin
        op_o       = OP_FALL;
        tmr_load_o = 1'b1;
        st_d       = ST_LOW;
      end
      ST_LOW: if (expired_i) begin
        if (last_i) st_d = ST_FIN;
        else begin
          step_o = 1'b1;
          st_d   = ST_ADDR;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign ready_o = (st_q == ST_IDLE);
  assign done_o  = (st_q == ST_FIN);
endmodule

// File: rtl/ptune_writer.sv
module ptune_writer #(
  parameter int unsigned NUM_PHY  = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HOLD_CYC = 2,
  localparam int unsigned PHY_W   = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1,
  localparam int unsigned LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [PHY_W-1:0]  req_phy_i,
  input  logic [7:0]        req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_clr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       ctl_o
);
  import ptw_pkg::*;

  logic             load, step, tmr_load, expired;
  logic             last, empty, cur_bit;
  logic [PHY_W-1:0] cur_phy;
  logic [ADDR_W-1:0] cur_addr;
  ptw_op_e          op;

  ptw_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_clr_i  (req_clr_i),
    .expired_i  (expired),
    .last_i     (last),
    .empty_i    (empty),
    .load_o     (load),
    .step_o     (step),
    .tmr_load_o (tmr_load),
    .op_o       (op),
    .busy_o     (busy_o),
    .ready_o    (req_ready_o),
    .done_o     (done_o)
  );

  ptw_req_reg #(.DATA_W(DATA_W), .PHY_W(PHY_W), .LEN_W(LEN_W)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .phy_i  (req_phy_i),
    .addr_i (req_addr_i),
    .data_i (req_data_i),
    .len_i  (req_len_i),
    .phy_o  (cur_phy),
    .addr_o (cur_addr),
    .bit_o  (cur_bit),
    .last_o (last),
    .empty_o(empty)
  );

  ptw_phase_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .expired_o(expired)
  );

  ptw_ctl_word #(.NUM_PHY(NUM_PHY), .PHY_W(PHY_W)) u_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .phy_i (cur_phy),
    .addr_i(cur_addr),
    .bit_i (cur_bit),
    .ctl_o (ctl_o)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int unsigned HOLD_CYC = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] ctl_o
);
  logic [3:0] stb;
  logic [2:0] odd;
  assign stb = {ctl_o[6], ctl_o[4], ctl_o[2], ctl_o[0]};
  assign odd = {ctl_o[5], ctl_o[3], ctl_o[1]};

  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb));

  p_odd_bits_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd == 3'b000);

  p_stable_while_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stb) |-> $stable(ctl_o[15:7]));

  p_busy_blocks_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  p_idle_word_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_valid_i) |=> $stable(ctl_o));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  if (HOLD_CYC >= 2) begin : g_hold
    p_high_min_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(|stb) |=> (|stb));
  end
endmodule

bind ptune_writer ptw_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ctl_o      (ctl_o)
);

// File: tb/sim_ptune_writer.sv
`timescale 1ns/1ps
module sim_ptune_writer;
  localparam int NPHY = 4;
  localparam int DW   = 8;
  localparam int H    = 2;
  localparam int PW   = 2;
  localparam int LW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [PW-1:0] req_phy = '0;
  logic [7:0]    req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_clr = 1'b0;
  logic          ready, busy, done;
  logic [15:0]   ctl;

  always #2.5 clk = ~clk;

  ptune_writer #(.NUM_PHY(NPHY), .DATA_W(DW), .HOLD_CYC(H)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_phy_i(req_phy), .req_addr_i(req_addr), .req_data_i(req_data),
    .req_len_i(req_len), .req_clr_i(req_clr), .busy_o(busy), .done_o(done),
    .ctl_o(ctl)
  );

  int total = 0;
  int bad = 0;
  int rise_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: expected per-cycle outputs and expected captures
  logic [15:0] q_ctl[$];
  bit          q_busy[$];
  bit          q_done[$];
  int          q_cp[$], q_ca[$], q_cb[$];
  logic [15:0] m_ctl = '0;
  bit          m_busy = 0, m_done = 0;

  task automatic push(input logic [15:0] w, input bit b, input bit d);
    q_ctl.push_back(w); q_busy.push_back(b); q_done.push_back(d);
  endtask

  task automatic gen(input int p, input int a, input int d, input int n, input bit c);
    logic [15:0] w;
    int nn;
    nn = (n > DW) ? DW : n;
    w = c ? 16'h0 : m_ctl;
    for (int k = 0; k < nn; k++) begin
      push(w, 1, 0);
      w[15:8] = 8'((a + k) % 256);
      push(w, 1, 0);
      w[7] = (d >> k) & 1;
      w[2*p] = 1'b0;
      for (int j = 0; j < H; j++) push(w, 1, 0);
      w[2*p] = 1'b1;
      q_cp.push_back(p); q_ca.push_back((a + k) % 256); q_cb.push_back((d >> k) & 1);
      for (int j = 0; j < H; j++) push(w, 1, 0);
      w[2*p] = 1'b0;
      for (int j = 0; j < H; j++) push(w, 1, 0);
    end
    if (nn == 0) push(w, 1, 0);
    push(w, 1, 1);
  endtask

  task automatic pop();
    m_ctl = q_ctl.pop_front(); m_busy = q_busy.pop_front(); m_done = q_done.pop_front();
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ctl.delete(); q_busy.delete(); q_done.delete();
      m_ctl = '0; m_busy = 0; m_done = 0;
    end else if (q_ctl.size() > 0) begin
      pop();
    end else if (!m_busy && req_valid) begin
      gen(int'(req_phy), int'(req_addr), int'(req_data), int'(req_len), req_clr);
      pop();
    end else begin
      m_busy = 0; m_done = 0;
    end
  end

  // per-cycle comparison and PHY-side capture model
  logic [15:0] prev_ctl = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] rises;
      chk(ctl == m_ctl, "R6 ctl word", int'(ctl), int'(m_ctl));
      chk(busy == m_busy, "R7 busy", int'(busy), int'(m_busy));
      chk(ready == !m_busy, "R7 ready", int'(ready), int'(!m_busy));
      chk(done == m_done, "R8 done", int'(done), int'(m_done));
      rises = ctl & ~prev_ctl & 16'h0055;
      if (rises != 0) begin
        rise_cnt++;
        if (q_cp.size() == 0) begin
          chk(0, "R2 unexpected strobe", int'(rises), 0);
        end else begin
          int p, a, b;
          p = q_cp.pop_front(); a = q_ca.pop_front(); b = q_cb.pop_front();
          chk(rises == (16'h1 << (2*p)), "R2 strobe bit", int'(rises), 1 << (2*p));
          chk(int'(ctl[15:8]) == a, "R3 captured address", int'(ctl[15:8]), a);
          chk(int'(ctl[7]) == b, "R3 captured bit", int'(ctl[7]), b);
          chk(prev_ctl[15:7] == ctl[15:7], "R4 addr/data set before strobe",
              int'(prev_ctl[15:7]), int'(ctl[15:7]));
        end
      end
    end
    prev_ctl = ctl;
  end

  task automatic send(input int p, input int a, input int d, input int n, input bit c);
    req_phy = PW'(p); req_addr = 8'(a); req_data = DW'(d); req_len = LW'(n); req_clr = c;
    req_valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_data = ~req_data; req_addr = ~req_addr; req_phy = ~req_phy; req_len = 4'hF;
  endtask

  task automatic busy_len(output int cnt);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (busy || q_ctl.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog actual=hung expected=idle");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl == 16'h0, "R1 ctl", int'(ctl), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single-bit calibration enable, length check R6
    send(0, 8'h0c, 1, 1, 1'b1);
    busy_len(cnt);
    chk(cnt == 1*(2+3*H)+1, "R6 busy length 1 bit", cnt, 1*(2+3*H)+1);
    wait_idle();

    // 5-bit amplitude value without clear: word retained R5
    send(1, 8'h20, 8'h14, 5, 1'b0);
    chk(ctl == 16'h0c80, "R5 word retained", int'(ctl), 16'h0c80);
    busy_len(cnt);
    chk(cnt == 5*(2+3*H)+1, "R6 busy length 5 bits", cnt, 5*(2+3*H)+1);
    wait_idle();

    // clear mode R5
    send(2, 8'h2a, 3, 2, 1'b1);
    chk(ctl == 16'h0, "R5 word cleared", int'(ctl), 0);
    wait_idle();

    // back-to-back chain: requests wait while busy R7, address wrap R3
    send(3, 8'h3c, 2, 2, 1'b0);
    send(0, 8'h3c, 0, 2, 1'b1);
    send(1, 8'hfe, 8'ha5, 4, 1'b0);
    wait_idle();
    chk(ctl[15:8] == 8'h01, "R3 address wrap", int'(ctl[15:8]), 1);

    // zero length R9
    r0 = rise_cnt;
    send(2, 8'h40, 8'hff, 0, 1'b0);
    busy_len(cnt);
    chk(cnt == 2, "R9 zero length busy", cnt, 2);
    wait_idle();
    chk(rise_cnt == r0, "R9 zero length no strobe", rise_cnt, r0);

    // oversize count clamped R9
    r0 = rise_cnt;
    send(3, 8'h80, 8'hc3, 15, 1'b1);
    wait_idle();
    chk(rise_cnt - r0 == DW, "R9 clamp", rise_cnt - r0, DW);

    // mixed patterns
    for (int i = 0; i < 6; i++) begin
      send(i % NPHY, (i * 53) % 256, (i * 37 + 11) % 256, 1 + (i % DW), i[0]);
    end
    wait_idle();
    chk(q_cp.size() == 0, "R3 all captures seen", q_cp.size(), 0);
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule